// File: doc/BRIEF.md
# Pin I/O Block with Per-Pin Interrupts on an APB Port

This block gives software control of up to 32 general-purpose pins through an APB slave port. Each pin has an output value, a drive-enable (direction) bit and a synchronized input sample. Every setting is changed by writing ones to a "set" address or a "clear" address of a pair. Bits written as zero are left as they are, so software never has to read a register before changing it.

Each pin can raise an interrupt request. The request can be level sensitive, where the status follows the synchronized pin, or edge sensitive, where the status is latched until software acknowledges it. Polarity picks high/rising or low/falling. A per-pin any-edge override makes an edge pin trigger on both transitions, whatever its polarity. A single interrupt line is the OR over pins of status AND enable. A loopback mode routes the output values into the input path in place of the pads, for self-test.

Registers sit at word offsets (byte offset = 4 × index). Bit n of every register belongs to pin n. Index: 0 pin sample (read) / output set (write); 1 interrupt status (read) / output clear (write); 2 drive enable set; 3 drive enable clear; 4 and 5 interrupt enable set / clear; 6 and 7 edge-sense set / level-sense set; 8 and 9 polarity high / polarity low; 10 and 11 any-edge set / clear; 12 interrupt acknowledge; 13 mode, where bit 0 = 1 selects loopback.

Top module: `gpio_apb_pins`

## Requirements
- R1: A write of ones to index 0 sets those bits of `pin_out`, and a write of ones to index 1 clears them. Zero bits leave the output unchanged. After reset `pin_out` is 0.
- R2: A write of ones to index 2 sets those bits of `pin_oe`, and a write of ones to index 3 clears them. After reset `pin_oe` is 0.
- R3: A read of index 0 returns the pin inputs after a two-flop synchronizer. A pin change is readable no later than the fourth clock edge after it.
- R4: The interrupt enable is set by index 4 and cleared by index 5. A read of either index returns the enable mask (1 = enabled). It resets to 0.
- R5: Index 6 makes pins edge sensitive and index 7 makes them level sensitive. A read of either returns the sense mask (1 = edge). It resets to 0 (all level).
- R6: Index 8 selects active high/rising and index 9 selects active low/falling. A read of either returns the polarity mask (1 = high). It resets to all ones.
- R7: An edge-sensitive pin latches its status bit on the selected edge of its synchronized input. With the any-edge bit set (index 10 sets it, index 11 clears it, a read returns the mask), it latches on both edges.
- R8: Writing ones to index 12 clears latched edge status bits. It has no effect on level-sensitive status.
- R9: A level-sensitive status bit is 1 exactly while the synchronized input equals the polarity bit. It is never latched.
- R10: A read of index 1 returns the per-pin status. `irq` is 1 exactly when some pin has status and enable both 1.
- R11: With mode bit 0 set (index 13, readable), the input path takes `pin_out` in place of `pin_in`. Samples and edge interrupts then follow the outputs.
- R12: Reads of indices 2, 3 and 12, and of any index above 13, return 0. Writes to those indices above 13 change nothing.
- R13: When a new edge on a pin and an acknowledge of that pin take effect in the same cycle, the status bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | APB clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1, no wait states |
| pslverr | output | 1 | Always 0 |
| pin_in | input | NPINS | Pad input values |
| pin_out | output | NPINS | Pad output values |
| pin_oe | output | NPINS | Pad drive enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The clash that matters is a fresh synchronized edge on a pin and a software acknowledge of the same pin arriving together. The bench raises pin 0 on one falling clock edge and starts the acknowledge write on the next. The write's access phase then commits on the same rising edge at which the rise detector fires, three edges after the pin change. The following status read must still show bit 0 set. A second acknowledge a few cycles later must clear it, which shows the bit was held by the new edge and not by a missed write.

// File: rtl/gpio_apb_pkg.sv
`timescale 1ns/1ps
package gpio_apb_pkg;
  localparam int DATA_W = 32;
  localparam int NREG   = 14;

  typedef enum logic [3:0] {
    RG_SAMPLE_OSET = 4'd0,
    RG_STAT_OCLR   = 4'd1,
    RG_DRV_SET     = 4'd2,
    RG_DRV_CLR     = 4'd3,
    RG_EN_SET      = 4'd4,
    RG_EN_CLR      = 4'd5,
    RG_SNS_EDGE    = 4'd6,
    RG_SNS_LEVEL   = 4'd7,
    RG_POL_HI      = 4'd8,
    RG_POL_LO      = 4'd9,
    RG_ANY_SET     = 4'd10,
    RG_ANY_CLR     = 4'd11,
    RG_ACK         = 4'd12,
    RG_MODE        = 4'd13
  } reg_idx_e;

  // Edge trigger for one pin: both edges when any-edge is set, otherwise
  // rising for polarity 1 and falling for polarity 0.
  function automatic logic edge_hit(input logic now_v, input logic prev_v,
                                    input logic pol, input logic any);
    logic rise, fall;
    rise = now_v & ~prev_v;
    fall = ~now_v & prev_v;
    return any ? (rise | fall) : (pol ? rise : fall);
  endfunction

  // Level match for one pin.
  function automatic logic level_hit(input logic now_v, input logic pol);
    return now_v == pol;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] raw,
  output logic [NPINS-1:0] now_q,
  output logic [NPINS-1:0] prev_q
);
  logic [NPINS-1:0] meta_q;
  logic [1:0]       warm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      now_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw;
      now_q  <= meta_q;
      prev_q <= now_q;
    end
  end

  // Counts cycles since reset so the delay check never looks before it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  assert_sync_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= 2'd2) |-> (now_q == $past(raw, 2)));
endmodule

// File: rtl/gpio_irq_cell.sv
`timescale 1ns/1ps
module gpio_irq_cell
  import gpio_apb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic now_v,
  input  logic prev_v,
  input  logic sense_edge,
  input  logic pol,
  input  logic any,
  input  logic ack,
  output logic trig,
  output logic status
);
  logic lat_q;

  assign trig = edge_hit(now_v, prev_v, pol, any);

  // A new edge wins over an acknowledge in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           lat_q <= 1'b0;
    else if (!sense_edge) lat_q <= 1'b0;
    else                  lat_q <= trig | (lat_q & ~ack);
  end

  assign status = sense_edge ? lat_q : level_hit(now_v, pol);

  assert_edge_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_edge && trig) |=> lat_q);
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_edge && ack && !trig) |=> !lat_q);
  assert_level_unlatched_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sense_edge) |=> !lat_q);
endmodule

// File: rtl/gpio_regfile.sv
`timescale 1ns/1ps
module gpio_regfile
  import gpio_apb_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [NPINS-1:0]  sample,
  input  logic [NPINS-1:0]  status,
  output logic [NPINS-1:0]  out_q,
  output logic [NPINS-1:0]  drv_q,
  output logic [NPINS-1:0]  en_q,
  output logic [NPINS-1:0]  sense_q,
  output logic [NPINS-1:0]  pol_q,
  output logic [NPINS-1:0]  any_q,
  output logic [NPINS-1:0]  ack,
  output logic              loop_q
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic             in_range;
  logic             wr_hit;
  logic             rd_hit;
  reg_idx_e         ridx;
  logic [NPINS-1:0] wbits;

  assign word_idx = paddr[ADDR_W-1:2];
  assign in_range = (int'(word_idx) < NREG);
  assign ridx     = reg_idx_e'(word_idx[3:0]);
  assign wr_hit   = psel & penable & pwrite & in_range;
  assign rd_hit   = psel & ~pwrite & in_range;
  assign wbits    = pwdata[NPINS-1:0];

  // Write-ones update of one mask: set, clear or keep.
  function automatic logic [NPINS-1:0] w1_update(input logic [NPINS-1:0] cur,
                                                 input logic [NPINS-1:0] ones,
                                                 input logic do_set,
                                                 input logic do_clr);
    logic [NPINS-1:0] nxt;
    nxt = cur;
    if (do_set) nxt = nxt | ones;
    if (do_clr) nxt = nxt & ~ones;
    return nxt;
  endfunction

  function automatic logic hit(input logic wr, input reg_idx_e a, input reg_idx_e b);
    return wr && (a == b);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      drv_q   <= '0;
      en_q    <= '0;
      sense_q <= '0;
      pol_q   <= '1;
      any_q   <= '0;
      loop_q  <= 1'b0;
    end else if (wr_hit) begin
      out_q   <= w1_update(out_q, wbits, hit(wr_hit, ridx, RG_SAMPLE_OSET),
                           hit(wr_hit, ridx, RG_STAT_OCLR));
      drv_q   <= w1_update(drv_q, wbits, hit(wr_hit, ridx, RG_DRV_SET),
                           hit(wr_hit, ridx, RG_DRV_CLR));
      en_q    <= w1_update(en_q, wbits, hit(wr_hit, ridx, RG_EN_SET),
                           hit(wr_hit, ridx, RG_EN_CLR));
      sense_q <= w1_update(sense_q, wbits, hit(wr_hit, ridx, RG_SNS_EDGE),
                           hit(wr_hit, ridx, RG_SNS_LEVEL));
      pol_q   <= w1_update(pol_q, wbits, hit(wr_hit, ridx, RG_POL_HI),
                           hit(wr_hit, ridx, RG_POL_LO));
      any_q   <= w1_update(any_q, wbits, hit(wr_hit, ridx, RG_ANY_SET),
                           hit(wr_hit, ridx, RG_ANY_CLR));
      if (ridx == RG_MODE) loop_q <= pwdata[0];
    end
  end

  assign ack = (wr_hit && ridx == RG_ACK) ? wbits : '0;

  always_comb begin
    prdata = '0;
    if (rd_hit) begin
      unique case (ridx)
        RG_SAMPLE_OSET:          prdata = DATA_W'(sample);
        RG_STAT_OCLR:            prdata = DATA_W'(status);
        RG_EN_SET,   RG_EN_CLR:  prdata = DATA_W'(en_q);
        RG_SNS_EDGE, RG_SNS_LEVEL: prdata = DATA_W'(sense_q);
        RG_POL_HI,   RG_POL_LO:  prdata = DATA_W'(pol_q);
        RG_ANY_SET,  RG_ANY_CLR: prdata = DATA_W'(any_q);
        RG_MODE:                 prdata = DATA_W'(loop_q);
        default:                 prdata = '0;
      endcase
    end
  end

  assert_drv_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && ridx == RG_DRV_SET) |=> ((drv_q & $past(wbits)) == $past(wbits)));
  assert_out_clr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && ridx == RG_STAT_OCLR) |=> ((out_q & $past(wbits)) == '0));
  assert_out_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_hit && (ridx == RG_SAMPLE_OSET || ridx == RG_STAT_OCLR)) |=> $stable(out_q));
endmodule

// File: rtl/gpio_apb_pins.sv
`timescale 1ns/1ps
module gpio_apb_pins
  import gpio_apb_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  logic [NPINS-1:0] out_q, drv_q, en_q, sense_q, pol_q, any_q, ack;
  logic [NPINS-1:0] raw, now_q, prev_q, trig, status;
  logic             loop_q;

  gpio_regfile #(.NPINS(NPINS), .ADDR_W(ADDR_W)) regs_i (
    .clk, .rst_n, .psel, .penable, .pwrite, .paddr, .pwdata, .prdata,
    .sample(now_q), .status, .out_q, .drv_q, .en_q, .sense_q, .pol_q,
    .any_q, .ack, .loop_q
  );

  assign raw = loop_q ? out_q : pin_in;

  gpio_sync #(.NPINS(NPINS)) sync_i (
    .clk, .rst_n, .raw, .now_q, .prev_q
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gpio_irq_cell cell_i (
      .clk, .rst_n,
      .now_v(now_q[p]), .prev_v(prev_q[p]),
      .sense_edge(sense_q[p]), .pol(pol_q[p]), .any(any_q[p]),
      .ack(ack[p]), .trig(trig[p]), .status(status[p])
    );
  end

  assign pin_out = out_q;
  assign pin_oe  = drv_q;
  assign irq     = |(status & en_q);
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);
  assert_loop_path_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_q && $past(loop_q)) |=> (sync_i.meta_q == $past(out_q)));
endmodule

// File: tb/gpio_apb_pins_tb_top.sv
`timescale 1ns/1ps
module gpio_apb_pins_tb_top;
  localparam int NPINS = 32;
  localparam int AW    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [AW-1:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr;
  logic [NPINS-1:0] pin_in = '0;
  logic [NPINS-1:0] pin_out, pin_oe;
  logic irq;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  gpio_apb_pins #(.NPINS(NPINS), .ADDR_W(AW)) dut_i (
    .clk, .rst_n, .psel, .penable, .pwrite, .paddr, .pwdata, .prdata,
    .pready, .pslverr, .pin_in, .pin_out, .pin_oe, .irq
  );

  function automatic logic [AW-1:0] a(input int idx);
    return AW'(idx * 4);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 1; penable = 0; paddr = a(idx); pwdata = d;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  // Driver: queue the expected read value, then run the read.
  task automatic rd(input int idx, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    psel = 1; pwrite = 0; penable = 0; paddr = a(idx);
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare each completed read against the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (psel && penable && !pwrite) begin
        if (exp_q.size() == 0) begin
          check("scoreboard underflow", prdata, 32'hx);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, prdata, e);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        misses++;
        vectors++;
        $display("FAIL watchdog actual=%0d expected<200000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
      end
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    // Reset state
    check("R1 reset pin_out", 32'(pin_out), 32'h0);
    check("R2 reset pin_oe", 32'(pin_oe), 32'h0);
    check("R10 reset irq", 32'(irq), 32'h0);
    rd(0, 32'h0, "R3 reset sample");
    rd(4, 32'h0, "R4 reset enable");
    rd(6, 32'h0, "R5 reset sense");
    rd(8, 32'hFFFF_FFFF, "R6 reset polarity");
    rd(13, 32'h0, "R11 reset mode");

    // R1 outputs
    wr(0, 32'h0000_00F5);
    check("R1 set", 32'(pin_out), 32'h0000_00F5);
    wr(1, 32'h0000_0005);
    check("R1 clear", 32'(pin_out), 32'h0000_00F0);

    // R2 direction
    wr(2, 32'h0000_FF00);
    check("R2 set", 32'(pin_oe), 32'h0000_FF00);
    wr(3, 32'h0000_0F00);
    check("R2 clear", 32'(pin_oe), 32'h0000_F000);

    // R12 write-only and unused indices
    rd(2, 32'h0, "R12 drive-set read");
    rd(3, 32'h0, "R12 drive-clear read");
    rd(12, 32'h0, "R12 ack read");
    wr(14, 32'hFFFF_FFFF);
    rd(14, 32'h0, "R12 unused read");
    check("R12 unused write pin_out", 32'(pin_out), 32'h0000_00F0);
    check("R12 unused write pin_oe", 32'(pin_oe), 32'h0000_F000);

    // R3 synchronized sample
    @(negedge clk); pin_in = 32'hA5A5_0001;
    idle(4);
    rd(0, 32'hA5A5_0001, "R3 sample pattern");
    @(negedge clk); pin_in = 32'h0;
    idle(4);
    rd(0, 32'h0, "R3 sample zero");

    // R4 enable
    wr(4, 32'h3);
    rd(4, 32'h3, "R4 enable via set idx");
    rd(5, 32'h3, "R4 enable via clr idx");
    wr(5, 32'h1);
    rd(4, 32'h2, "R4 enable after clear");

    // R5 sense
    wr(6, 32'h3);
    rd(7, 32'h3, "R5 sense via level idx");
    wr(7, 32'h2);
    rd(6, 32'h1, "R5 sense after level");

    // R6 polarity: pin1 active low
    wr(9, 32'h2);
    rd(8, 32'hFFFF_FFFD, "R6 polarity low");

    // R9/R10 level pin1 active low, pin low -> status
    idle(2);
    rd(1, 32'h2, "R9 level active-low asserted");
    check("R10 irq on", 32'(irq), 32'h1);
    @(negedge clk); pin_in[1] = 1'b1;
    idle(4);
    rd(1, 32'h0, "R9 level deasserted");
    check("R10 irq off", 32'(irq), 32'h0);
    @(negedge clk); pin_in[1] = 1'b0;
    idle(4);
    wr(12, 32'h2);
    rd(1, 32'h2, "R8 ack ignores level");
    wr(5, 32'h2);
    check("R10 irq masked", 32'(irq), 32'h0);

    // R7 rising edge on pin0
    @(negedge clk); pin_in[0] = 1'b1;
    idle(4);
    rd(1, 32'h3, "R7 rising latched");
    @(negedge clk); pin_in[0] = 1'b0;
    idle(4);
    rd(1, 32'h3, "R7 latch held after pin falls");
    wr(4, 32'h1);
    check("R10 irq from edge", 32'(irq), 32'h1);
    wr(12, 32'h1);
    rd(1, 32'h2, "R8 ack clears edge");
    check("R10 irq after ack", 32'(irq), 32'h0);

    // R7 falling edge
    wr(9, 32'h1);
    @(negedge clk); pin_in[0] = 1'b1;
    idle(4);
    rd(1, 32'h2, "R7 falling mode ignores rise");
    @(negedge clk); pin_in[0] = 1'b0;
    idle(4);
    rd(1, 32'h3, "R7 falling latched");
    wr(12, 32'h1);

    // R7 any-edge
    wr(10, 32'h1);
    rd(11, 32'h1, "R7 any-edge mask");
    @(negedge clk); pin_in[0] = 1'b1;
    idle(4);
    rd(1, 32'h3, "R7 any-edge rise");
    wr(12, 32'h1);
    @(negedge clk); pin_in[0] = 1'b0;
    idle(4);
    rd(1, 32'h3, "R7 any-edge fall");
    wr(12, 32'h1);
    wr(11, 32'h1);
    @(negedge clk); pin_in[0] = 1'b1;
    idle(4);
    rd(1, 32'h2, "R7 any-edge removed");

    // R13 edge and ack in the same cycle
    wr(8, 32'h1);
    @(negedge clk); pin_in[0] = 1'b0;
    idle(4);
    wr(12, 32'h1);
    rd(1, 32'h2, "R13 precondition clear");
    @(negedge clk); pin_in[0] = 1'b1;
    wr(12, 32'h1);
    rd(1, 32'h3, "R13 edge wins over ack");
    wr(12, 32'h1);
    rd(1, 32'h2, "R13 later ack clears");

    // R11 loopback
    wr(13, 32'h1);
    rd(13, 32'h1, "R11 mode read");
    idle(4);
    rd(0, 32'h0000_00F0, "R11 loopback sample");
    wr(0, 32'h1);
    idle(4);
    rd(0, 32'h0000_00F1, "R11 loopback follows output");
    rd(1, 32'h0000_00F3, "R11 loopback edge latched");
    wr(13, 32'h0);
    wr(12, 32'h1);
    idle(4);
    rd(0, 32'h0000_0001, "R11 normal mode restored");

    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule